// File: doc/BRIEF.md
# Iterative Double-Width Multiplier with Half Select

This block multiplies two 64-bit operands over a series of clock cycles and returns one 64-bit half of the 128-bit product. The caller picks the half and its interpretation: the low half (signedness does not matter there), the high half with both operands read as two's-complement, or the high half with both operands read as unsigned. One shift-and-add datapath serves all three. Each cycle it makes one conditional addition of the multiplicand into the upper half of a 128-bit accumulator, and shifts the whole accumulator right in the same cycle.

A request is a one-cycle `start` pulse while `busy` is low, with the operands and the operation code valid in that cycle. The block captures them at that edge, which is also the setup step. It then runs 64 accumulate cycles and one finish cycle. In the finish cycle the sign correction is applied and the chosen half is registered. `done` pulses for one cycle with `result` valid, and `result` then holds until the next completion. For the signed high half, the block multiplies the operand magnitudes. It negates the 128-bit product when exactly one operand is negative.

Top module: `iter_mult`

## Requirements
- R1: While reset is low, and after it is released with no request issued, `busy`, `done` and `result` are all zero.
- R2: Operation code 0 returns bits 63:0 of the 128-bit product. These bits are the same whether the operands are read as signed or unsigned.
- R3: Operation code 1 returns bits 127:64 of the product with both operands read as two's-complement values.
- R4: Operation code 2 returns bits 127:64 of the product with both operands read as unsigned values.
- R5: Operation code 3 behaves exactly like code 0 and returns bits 63:0 of the product.
- R6: If `start` is sampled with `busy` low at clock edge N, `done` is high for exactly one cycle, after edge N+65, with `result` valid. `result` then stays unchanged until the next completion.
- R7: `busy` is high from the edge that accepts a request up to the finish cycle. It is low in the cycle where `done` is high.
- R8: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands and operation code and returns its own result, and the ignored pulse produces no extra `done`.
- R9: A new request issued in the same cycle that `done` is high is accepted and completes normally.
- R10: The corner operands give exact results: the most negative value times itself, any operand times zero, and all-ones times all-ones, in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe, honoured only when idle |
| opSel | input | 2 | Operation code: 0 low half, 1 signed high half, 2 unsigned high half, 3 same as 0 |
| opA | input | 64 | Multiplicand, sampled on the accepting edge |
| opB | input | 64 | Multiplier, sampled on the accepting edge |
| result | output | 64 | Selected product half, held between completions |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | High while a request is in progress |

## Verification
Every result is due exactly 65 clock edges after the edge that accepts its `start`. The driver records that due cycle along with the expected half of the product, which the bench computes with 128-bit arithmetic of its own. The monitor samples on the falling edge. Each time `done` is high it pops the oldest entry and compares both the value and the cycle count, so a late, early or missing strobe fails just as a wrong value does. Requests that should be ignored are never queued, so any extra `done` finds an empty queue and is reported.

// File: rtl/mult_pkg.sv
package mult_pkg;

  // Operation codes carried on opSel
  typedef enum logic [1:0] {
    OP_LOW   = 2'd0,
    OP_HI_S  = 2'd1,
    OP_HI_U  = 2'd2,
    OP_RSVD  = 2'd3
  } mulOp_e;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic step;    // one add-and-shift iteration
    logic finish;  // sign fix and half select
  } mulCtl_t;

endpackage

// File: rtl/mult_cond_negate.sv
module mult_cond_negate #(
  parameter int N = 64
) (
  input  logic [N-1:0] din,
  input  logic         neg,
  output logic [N-1:0] dout
);

  always_comb begin
    if (neg) dout = ~din + N'(1);
    else     dout = din;
  end

endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int W = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mulCtl_t ctl,
  output logic    done,
  output logic    busy
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e        state;
  logic [CW-1:0] iterCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            iterCnt <= '0;
          end
        end
        S_RUN: begin
          iterCnt <= iterCnt + CW'(1);
          if (iterCnt == LAST) state <= S_FIN;
        end
        S_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load   = (state == S_IDLE) && start;
    ctl.step   = (state == S_RUN);
    ctl.finish = (state == S_FIN);
    busy       = (state != S_IDLE);
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  last_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && iterCnt == LAST) |=> (ctl.finish && busy));

  // R7
  busy_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> busy);

  // R6
  finish_to_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> done);

endmodule

// File: rtl/mult_datapath.sv
module mult_datapath
  import mult_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  mulCtl_t      ctl,
  input  mulOp_e       opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result
);

  localparam int PW = 2 * W;

  logic [W-1:0]  mcand;
  logic [W-1:0]  accHi;
  logic [W-1:0]  accLo;
  logic          negRes;
  mulOp_e        opReg;

  logic          signedHi;
  logic [W-1:0]  magA;
  logic [W-1:0]  magB;
  logic [W:0]    addend;
  logic [W:0]    stepSum;
  logic [PW-1:0] rawProd;
  logic [PW-1:0] fixProd;

  assign signedHi = (opSel == OP_HI_S);

  mult_cond_negate #(.N(W)) u_absA (
    .din  (opA),
    .neg  (signedHi && opA[W-1]),
    .dout (magA)
  );

  mult_cond_negate #(.N(W)) u_absB (
    .din  (opB),
    .neg  (signedHi && opB[W-1]),
    .dout (magB)
  );

  // one partial-product addition into the upper half
  always_comb begin
    addend  = accLo[0] ? {1'b0, mcand} : '0;
    stepSum = {1'b0, accHi} + addend;
    rawProd = {accHi, accLo};
  end

  mult_cond_negate #(.N(PW)) u_fix (
    .din  (rawProd),
    .neg  (negRes),
    .dout (fixProd)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcand  <= '0;
      accHi  <= '0;
      accLo  <= '0;
      negRes <= 1'b0;
      opReg  <= OP_LOW;
      result <= '0;
    end else if (ctl.load) begin
      mcand  <= magA;
      accLo  <= magB;
      accHi  <= '0;
      negRes <= signedHi && (opA[W-1] ^ opB[W-1]);
      opReg  <= opSel;
    end else if (ctl.step) begin
      // add and shift in the same cycle
      accHi <= stepSum[W:1];
      accLo <= {stepSum[0], accLo[W-1:1]};
    end else if (ctl.finish) begin
      unique case (opReg)
        OP_HI_S, OP_HI_U: result <= fixProd[PW-1:W];
        default:          result <= fixProd[W-1:0];
      endcase
    end
  end

  // R8
  hold_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(mcand) && $stable(opReg) && $stable(negRes)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.finish |=> $stable(result));

  // R2
  low_no_negate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && (opReg == OP_LOW || opReg == OP_HI_U || opReg == OP_RSVD)) |-> !negRes);

endmodule

// File: rtl/iter_mult.sv
module iter_mult
  import mult_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         done,
  output logic         busy
);

  mulCtl_t ctl;

  mult_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .done  (done),
    .busy  (busy)
  );

  mult_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opSel  (mulOp_e'(opSel)),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: tb/iter_mult_bench.sv
`timescale 1ns/1ps
module iter_mult_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] result;
  logic        done;
  logic        busy;

  int checks = 0;
  int failures = 0;
  int pushes = 0;
  int pops = 0;
  longint cyc = 0;
  logic finished = 1'b0;

  typedef struct {
    logic [63:0] val;
    longint      due;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) cyc <= cyc + 1;

  iter_mult u_iter_mult (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .opA(opA), .opB(opB), .result(result), .done(done), .busy(busy)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [127:0] pu;
    logic signed [127:0] ps;
    pu = {64'b0, a} * {64'b0, b};
    ps = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    case (op)
      2'd1:    return ps[127:64];
      2'd2:    return pu[127:64];
      default: return pu[63:0];
    endcase
  endfunction

  // driver: called at a falling edge with busy low
  task automatic issue(input logic [1:0] op, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    opSel = op; opA = a; opB = b; start = 1'b1;
    e.val = model(op, a, b);
    e.due = cyc + 66;
    e.tag = tag;
    expQ.push_back(e);
    pushes++;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", {63'b0, busy}, 64'd1);
  endtask

  task automatic drain();
    while (expQ.size() != 0 || busy) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      check(busy == 1'b0, "R7 busy low with done", {63'b0, busy}, 64'd0);
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        pops++;
        check(result == e.val, e.tag, result, e.val);
        check(cyc == e.due, {"R6 latency ", e.tag}, 64'(cyc), 64'(e.due));
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && result == 0, "R1 during reset", result, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && done == 0 && result == 0, "R1 after reset", result, 64'd0);

    // R2 low half
    issue(2'd0, 64'd7, 64'd9, "R2 small");
    issue(2'd0, 64'hDEAD_BEEF_1234_5678, 64'h0FED_CBA9_8765_4321, "R2 large");
    issue(2'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, "R2 negative operand");
    // R3 signed high
    issue(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R3 minus one times one");
    issue(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3 minus one squared");
    issue(2'd1, 64'h8123_4567_89AB_CDEF, 64'h7654_3210_FEDC_BA98, "R3 mixed signs");
    issue(2'd1, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000, "R3 pos times neg");
    // R4 unsigned high
    issue(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4 all ones");
    issue(2'd2, 64'h8123_4567_89AB_CDEF, 64'h7654_3210_FEDC_BA98, "R4 mixed");
    // R5 reserved code
    issue(2'd3, 64'hDEAD_BEEF_1234_5678, 64'h0FED_CBA9_8765_4321, "R5 code three");
    // R10 corners
    issue(2'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R10 most negative squared signed");
    issue(2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R10 most negative squared unsigned");
    issue(2'd1, 64'h8000_0000_0000_0000, 64'd0, "R10 times zero signed");
    issue(2'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R10 zero low");
    issue(2'd1, 64'h8000_0000_0000_0000, 64'd1, "R10 most negative times one");
    drain();

    // R6 result held after done
    issue(2'd2, 64'h1234_5678_9ABC_DEF0, 64'h0FF0_0FF0_0FF0_0FF0, "R6 hold source");
    drain();
    repeat (7) @(negedge clk);
    held = model(2'd2, 64'h1234_5678_9ABC_DEF0, 64'h0FF0_0FF0_0FF0_0FF0);
    check(result == held && done == 0, "R6 result held", result, held);

    // R8 start while busy ignored
    issue(2'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd3, "R8 running op");
    repeat (10) @(negedge clk);
    opSel = 2'd2; opA = 64'hFFFF_FFFF_FFFF_FFFF; opB = 64'hFFFF_FFFF_FFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (80) @(negedge clk);
    check(pops == pushes && busy == 0, "R8 no extra completion", 64'(pops), 64'(pushes));

    // R9 back-to-back on done
    issue(2'd0, 64'd123456789, 64'd987654321, "R9 first");
    while (!done) @(negedge clk);
    issue(2'd1, 64'hFFFF_FFFF_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, "R9 second");
    drain();
    repeat (3) @(negedge clk);
    check(pops == pushes, "R9 all completed", 64'(pops), 64'(pushes));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule